// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a four-wire serial slave that owns a bank of configuration registers and shows their contents as one flat parallel bus. An external controller holds the active-low enable low for one transfer window. It clocks command bits in on the serial clock and lifts the enable to commit the command. A command is a direction bit, then a register address, then a data byte, each sent most significant bit first. A write lands in the addressed register when the enable is released. A read is deferred. It only names a register, and that register's byte is shifted out on the data output during the following window, while the controller may already be sending its next command.

All four serial pins are treated as asynchronous to the master clock. They pass through a multi-stage synchronizer, and every decision is taken in the master-clock domain from detected edges of the synchronized serial clock and enable. For this reason the serial clock must be a few times slower than the master clock. The enable must also stay high for a minimum number of master-clock cycles between windows. A window that opens too early is flagged and ignored.

Top module: `cfg_serial_port`

## Requirements
- R1: While reset is asserted, every register reads zero, the data output is low and the protocol-error flag is low.
- R2: A command whose direction bit is 0 (write) stores its eight data bits into the register selected by its four address bits once the enable rises. Bit order on the data input is direction, address MSB first, data MSB first, and register n occupies bits [8n+7:8n] of the parallel bus. No other register changes.
- R3: When more than thirteen bits are clocked in during one window, only the last thirteen are decoded.
- R4: A window that delivers fewer than thirteen bits changes no register.
- R5: A command whose direction bit is 1 (read) changes no register, whatever its data bits hold.
- R6: In the window that follows an accepted read, the first eight falling serial-clock edges put the named register's bits on the data output, MSB first. After the eighth, the output is low until the window ends.
- R7: With no read pending, and whenever the enable has been high for a few master-clock cycles, the data output is low.
- R8: If the enable falls after being high for fewer than three master-clock cycles, the protocol-error flag goes high, that window's command is ignored, and a pending read is not served in it.
- R9: A gap of exactly three master-clock cycles is accepted. The error flag returns low when such a window opens, and a read still pending is served then.
- R10: A read is served in one window only. The window after that sees a low data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all state is in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous to mclk, idles low |
| sdi | input | 1 | Serial data in, sampled on rising sclk |
| sen_n | input | 1 | Active-low transfer enable |
| sdo | output | 1 | Serial data out, updated after falling sclk |
| proto_err | output | 1 | High after a window opened too soon after the last |
| cfg_q | output | 128 | All registers concatenated, register 0 in the low byte |

## Verification
The checker watches four things on every cycle: the bank changes only in the few cycles after the enable rises, the data output is quiet once the enable has been high for a short while, the data output and the error flag rise only inside a window, and reset clears every output. Other behaviour only shows at the ports across a series of windows, and only the bench scenarios can cover it. This includes decoding of the trailing thirteen bits, discarding of short frames, the deferred read arriving one window later and only once, and the exact boundary between a two-cycle and a three-cycle gap. The bench writes every address, reads every address back through the pipelined read path, and then covers those cases one by one.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
   // Direction bit carried at the head of every command.
   typedef enum logic {
      OP_WRITE = 1'b0,
      OP_READ  = 1'b1
   } cfg_op_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= {STAGES{RST_VAL}};
      else        stg_q <= {stg_q[STAGES-2:0], d};
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_frame.sv
module cfg_frame
   import cfg_serial_pkg::*;
#(
   parameter int AW      = 4,
   parameter int DW      = 8,
   parameter int GAP_MIN = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sclk_s,
   input  logic          sdi_s,
   input  logic          sen_s,
   output logic          sclk_fall,
   output logic          win_start,
   output logic          win_end,
   output logic          wr_en,
   output logic          rd_req,
   output logic [AW-1:0] cmd_addr,
   output logic [DW-1:0] cmd_data,
   output logic          proto_err
);
   localparam int FW = 1 + AW + DW;
   localparam int CW = $clog2(FW + 1);
   localparam int GW = $clog2(GAP_MIN + 1);

   logic          sclk_q, sen_q;
   logic [GW-1:0] hi_cnt;
   logic          gap_ok, win_ok, err_q;
   logic [FW-1:0] shift_q;
   logic [CW-1:0] bit_cnt;
   logic          sclk_rise, sen_fall, frame_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         sen_q  <= 1'b1;
      end else begin
         sclk_q <= sclk_s;
         sen_q  <= sen_s;
      end
   end

   assign sclk_rise = sclk_s & ~sclk_q;
   assign sclk_fall = ~sclk_s & sclk_q;
   assign sen_fall  = ~sen_s & sen_q;
   assign win_end   = sen_s & ~sen_q;

   // Length of the idle gap, saturating at the minimum.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       hi_cnt <= '0;
      else if (!sen_s)                  hi_cnt <= '0;
      else if (hi_cnt != GW'(GAP_MIN))  hi_cnt <= hi_cnt + 1'b1;
   end

   assign gap_ok    = (hi_cnt == GW'(GAP_MIN));
   assign win_start = sen_fall & gap_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_ok  <= 1'b0;
         err_q   <= 1'b0;
         shift_q <= '0;
         bit_cnt <= '0;
      end else if (sen_fall) begin
         win_ok  <= gap_ok;
         err_q   <= ~gap_ok;
         bit_cnt <= '0;
      end else if (sclk_rise && !sen_s && win_ok) begin
         shift_q <= {shift_q[FW-2:0], sdi_s};
         if (bit_cnt != CW'(FW)) bit_cnt <= bit_cnt + 1'b1;
      end
   end

   assign frame_ok  = win_end & win_ok & (bit_cnt == CW'(FW));
   assign wr_en     = frame_ok & (shift_q[FW-1] == OP_WRITE);
   assign rd_req    = frame_ok & (shift_q[FW-1] == OP_READ);
   assign cmd_addr  = shift_q[FW-2 -: AW];
   assign cmd_data  = shift_q[DW-1:0];
   assign proto_err = err_q;
endmodule

// File: rtl/cfg_shout.sv
module cfg_shout #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_req,
   input  logic [AW-1:0] rd_addr,
   input  logic          win_start,
   input  logic          win_end,
   input  logic          sclk_fall,
   input  logic [DW-1:0] rd_data,
   output logic [AW-1:0] pend_addr,
   output logic          sdo
);
   localparam int LW = $clog2(DW + 1);

   logic          pend_q;
   logic [AW-1:0] pend_addr_q;
   logic [DW-1:0] sh_q;
   logic [LW-1:0] left_q;
   logic          sdo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_addr_q <= '0;
      end else if (rd_req) begin
         pend_q      <= 1'b1;
         pend_addr_q <= rd_addr;
      end else if (win_start) begin
         pend_q      <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
         sdo_q  <= 1'b0;
      end else if (win_end) begin
         left_q <= '0;
         sdo_q  <= 1'b0;
      end else if (win_start && pend_q) begin
         sh_q   <= rd_data;
         left_q <= LW'(DW);
      end else if (sclk_fall) begin
         if (left_q != '0) begin
            sdo_q  <= sh_q[DW-1];
            sh_q   <= {sh_q[DW-2:0], 1'b0};
            left_q <= left_q - 1'b1;
         end else begin
            sdo_q  <= 1'b0;
         end
      end
   end

   assign pend_addr = pend_addr_q;
   assign sdo       = sdo_q;
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [DW-1:0]      wr_data,
   input  logic [AW-1:0]      rd_addr,
   output logic [DW-1:0]      rd_data,
   output logic [(1<<AW)*DW-1:0] bank_q
);
   localparam int NREG = 1 << AW;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            r_q <= '0;
         else if (wr_en && wr_addr == AW'(g))   r_q <= wr_data;
      end
      assign bank_q[g*DW +: DW] = r_q;
   end

   assign rd_data = bank_q[rd_addr*DW +: DW];
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
   parameter int AW          = 4,
   parameter int DW          = 8,
   parameter int GAP_MIN     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   mclk,
   input  logic                   rst_n,
   input  logic                   sclk,
   input  logic                   sdi,
   input  logic                   sen_n,
   output logic                   sdo,
   output logic                   proto_err,
   output logic [(1<<AW)*DW-1:0]  cfg_q
);
   if (AW < 1 || AW > 6) begin : g_bad_aw
      $error("cfg_serial_port: AW out of range");
   end
   if (DW < 2) begin : g_bad_dw
      $error("cfg_serial_port: DW must be at least 2");
   end
   if (GAP_MIN < 1) begin : g_bad_gap
      $error("cfg_serial_port: GAP_MIN must be positive");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cfg_serial_port: need two or more sync stages");
   end

   logic          sen_s, sclk_s, sdi_s;
   logic          sclk_fall, win_start, win_end, wr_en, rd_req;
   logic [AW-1:0] cmd_addr, pend_addr;
   logic [DW-1:0] cmd_data, rd_data;

   cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
      .clk   (mclk),
      .rst_n (rst_n),
      .d     ({sen_n, sclk, sdi}),
      .q     ({sen_s, sclk_s, sdi_s})
   );

   cfg_frame #(.AW(AW), .DW(DW), .GAP_MIN(GAP_MIN)) i_frame (
      .clk       (mclk),
      .rst_n     (rst_n),
      .sclk_s    (sclk_s),
      .sdi_s     (sdi_s),
      .sen_s     (sen_s),
      .sclk_fall (sclk_fall),
      .win_start (win_start),
      .win_end   (win_end),
      .wr_en     (wr_en),
      .rd_req    (rd_req),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data),
      .proto_err (proto_err)
   );

   cfg_regbank #(.AW(AW), .DW(DW)) i_bank (
      .clk     (mclk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (cmd_addr),
      .wr_data (cmd_data),
      .rd_addr (pend_addr),
      .rd_data (rd_data),
      .bank_q  (cfg_q)
   );

   cfg_shout #(.AW(AW), .DW(DW)) i_shout (
      .clk       (mclk),
      .rst_n     (rst_n),
      .rd_req    (rd_req),
      .rd_addr   (cmd_addr),
      .win_start (win_start),
      .win_end   (win_end),
      .sclk_fall (sclk_fall),
      .rd_data   (rd_data),
      .pend_addr (pend_addr),
      .sdo       (sdo)
   );
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input logic                   mclk,
   input logic                   rst_n,
   input logic                   sen_n,
   input logic                   sdo,
   input logic                   proto_err,
   input logic [(1<<AW)*DW-1:0]  cfg_q
);
   logic       sen_prev, rst_seen;
   logic [2:0] rise_age, hi_run;

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         sen_prev <= 1'b1;
         rise_age <= 3'd7;
         hi_run   <= 3'd0;
      end else begin
         sen_prev <= sen_n;
         if (sen_n && !sen_prev)  rise_age <= 3'd0;
         else if (rise_age != 3'd7) rise_age <= rise_age + 3'd1;
         if (!sen_n)              hi_run <= 3'd0;
         else if (hi_run != 3'd7) hi_run <= hi_run + 3'd1;
      end
   end

   always_ff @(posedge mclk) begin
      rst_seen <= !rst_n;
      if (!rst_n && rst_seen) begin
         assert_reset_clear_R1: assert (cfg_q == '0 && !sdo && !proto_err)
            else $error("reset state not clear");
      end
   end

   // R2: bank contents move only just after the enable is released
   assert_cfg_change_at_release_R2: assert property (@(posedge mclk) disable iff (!rst_n)
      (cfg_q != $past(cfg_q)) |-> (rise_age <= 3'd4));

   // R7: output quiet once the enable has been high a few cycles
   assert_sdo_idle_R7: assert property (@(posedge mclk) disable iff (!rst_n)
      (hi_run >= 3'd4) |-> !sdo);

   // R6: read data only appears inside a window
   assert_sdo_in_window_R6: assert property (@(posedge mclk) disable iff (!rst_n)
      $rose(sdo) |-> !sen_n);

   // R8: error is raised as a window opens
   assert_err_on_open_R8: assert property (@(posedge mclk) disable iff (!rst_n)
      $rose(proto_err) |-> !sen_n);
endmodule

bind cfg_serial_port cfg_serial_port_chk #(.AW(AW), .DW(DW)) i_chk (
   .mclk      (mclk),
   .rst_n     (rst_n),
   .sen_n     (sen_n),
   .sdo       (sdo),
   .proto_err (proto_err),
   .cfg_q     (cfg_q)
);

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int NREG = 1 << AW;
   localparam int H = 6;

   logic mclk = 1'b0;
   logic rst_n, sclk, sdi, sen_n;
   logic sdo, proto_err;
   logic [NREG*DW-1:0] cfg_q;

   int vec = 0;
   int bad = 0;
   bit done = 0;
   logic [DW-1:0] exp_q [NREG];
   logic [31:0] rdo;
   logic        e;

   always #5 mclk = ~mclk;

   cfg_serial_port #(.AW(AW), .DW(DW), .GAP_MIN(3), .SYNC_STAGES(2)) i_cfg_serial_port (
      .mclk (mclk), .rst_n (rst_n), .sclk (sclk), .sdi (sdi), .sen_n (sen_n),
      .sdo (sdo), .proto_err (proto_err), .cfg_q (cfg_q)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      vec++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic check_bank(input string req);
      for (int r = 0; r < NREG; r++) chk(req, 32'(cfg_q[r*DW +: DW]), 32'(exp_q[r]));
   endtask

   task automatic settle();
      repeat (8) @(negedge mclk);
   endtask

   // Enable held high for 'gap' cycles, then nbits sent MSB first.
   task automatic frame(input int gap, input int nbits, input logic [31:0] bits,
                        output logic [31:0] got, output logic err_seen);
      repeat (gap) @(negedge mclk);
      sen_n = 1'b0;
      repeat (4) @(negedge mclk);
      got = '0;
      for (int i = nbits - 1; i >= 0; i--) begin
         sdi = bits[i];
         repeat (H) @(negedge mclk);
         sclk = 1'b1;
         repeat (H) @(negedge mclk);
         sclk = 1'b0;
         repeat (H) @(negedge mclk);
         got = {got[30:0], sdo};
      end
      err_seen = proto_err;
      sdi = 1'b0;
      @(negedge mclk);
      sen_n = 1'b1;
   endtask

   function automatic logic [31:0] cmd(input logic rw, input logic [3:0] a, input logic [7:0] d);
      return {19'd0, rw, a, d};
   endfunction

   initial begin
      repeat (200000) @(posedge mclk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; sclk = 1'b0; sdi = 1'b0; sen_n = 1'b1;
      for (int r = 0; r < NREG; r++) exp_q[r] = '0;
      repeat (4) @(negedge mclk);
      check_bank("R1");
      chk("R1 sdo", 32'(sdo), 0);
      chk("R1 err", 32'(proto_err), 0);
      rst_n = 1'b1;
      settle();

      // R2 write sweep, R7 quiet output with nothing pending
      for (int a = 0; a < NREG; a++) begin
         logic [7:0] d = 8'((a * 37 + 5) & 8'hFF);
         frame(4, 13, cmd(1'b0, 4'(a), d), rdo, e);
         exp_q[a] = d;
         chk("R7", rdo, 0);
      end
      settle();
      check_bank("R2");

      // R6 pipelined read of every address, R5 reads alter nothing
      for (int a = 0; a < NREG; a++) begin
         frame(4, 13, cmd(1'b1, 4'(a), 8'hA5 ^ 8'(a)), rdo, e);
         if (a > 0) begin
            chk("R6 byte", 32'(rdo[12:5]), 32'(exp_q[a-1]));
            chk("R6 tail", 32'(rdo[4:0]), 0);
         end
      end
      settle();
      check_bank("R5");

      // R4 short frame (8 bits) carries the last readout but writes nothing
      frame(4, 8, 32'h0000_0003, rdo, e);
      chk("R6 last", rdo, 32'(exp_q[NREG-1]));
      settle();
      check_bank("R4");

      // R10 read served once only
      frame(4, 13, cmd(1'b0, 4'd3, 8'h5C), rdo, e);
      exp_q[3] = 8'h5C;
      chk("R10", rdo, 0);

      // R3 extra leading bits are dropped
      frame(4, 16, {16'd0, 3'b101, cmd(1'b0, 4'd7, 8'hC3)}, rdo, e);
      exp_q[7] = 8'hC3;
      settle();
      check_bank("R3");

      // R8 short gap ignored, R9 three-cycle gap accepted
      frame(4, 13, cmd(1'b1, 4'd9, 8'h00), rdo, e);
      frame(2, 13, cmd(1'b0, 4'd9, 8'hEE), rdo, e);
      chk("R8 err", 32'(e), 1);
      chk("R8 no readout", rdo, 0);
      frame(3, 13, cmd(1'b0, 4'd2, 8'h11), rdo, e);
      exp_q[2] = 8'h11;
      chk("R9 err", 32'(e), 0);
      chk("R9 readout", 32'(rdo[12:5]), 32'(exp_q[9]));
      settle();
      check_bank("R8");
      chk("R9 flag", 32'(proto_err), 0);

      frame(4, 13, cmd(1'b0, 4'd9, 8'h77), rdo, e);
      frame(2, 13, cmd(1'b0, 4'd4, 8'h99), rdo, e);
      chk("R8 err2", 32'(e), 1);
      frame(3, 13, cmd(1'b0, 4'd5, 8'h3A), rdo, e);
      exp_q[9] = 8'h77;
      exp_q[5] = 8'h3A;
      chk("R9 err2", 32'(e), 0);
      settle();
      check_bank("R9");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end
endmodule